// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Controller

This block holds the machine-mode control and status registers of a 32-bit integer core and decides, each cycle, whether the pipeline is redirected. It stores the interrupt-enable bits, the per-source interrupt enables, the trap vector, a scratch register, the exception return address, the cause and the trap value. It also presents a fixed ISA identification word, a pending-interrupt view taken straight from the three interrupt lines, and read-only views of three 64-bit counters. A window of 64 CSR addresses is passed through to an attached coprocessor.

The core presents one instruction per cycle along with its fault flags, system-op decodes (environment call, return from trap, wait for interrupt) and CSR write request. Everything that steers the pipeline is combinational in the same cycle: a redirect flag, the redirect address and an advance enable. Register updates land on the next rising edge. A two-state machine, `ST_RUN` and `ST_WAIT`, tracks whether a wait-for-interrupt is parked. `RUN_TO_WAIT` is taken by an accepted wait instruction. `WAIT_TO_RUN` is taken when any enabled interrupt line is pending, and in that case the global enable decides whether this is a trap or a plain resume.

Top module: `mtrap_ctrl`

## Requirements
- R1: After synchronous reset the status, enable, vector, return-address, cause, value and scratch registers all read 0, `advance` is 1 and `trap_taken` is 0.
- R2: CSRs are read on `csr_rdata` from `csr_addr` in the same cycle. Status is 0x300 (global enable at bit 3, saved enable at bit 7, other bits read 0). Enables are 0x304 (bits 3 software, 7 timer, 11 external, others 0). Vector is 0x305 (bits 1:0 always read 0). Scratch is 0x340, return address 0x341, cause 0x342 and value 0x343. Any other address outside the counter and coprocessor ranges reads 0.
- R3: Address 0x301 reads 0x40000100 and 0x344 reads bit 11 = `irq_ext`, bit 7 = `irq_tmr`, bit 3 = `irq_sw`. Writes to either have no effect.
- R4: 0xC00, 0xC01 and 0xC02 read bits 31:0 of `cnt_cycle`, `cnt_time` and `cnt_instret`. 0xC80, 0xC81 and 0xC82 read bits 63:32 of the same counters.
- R5: When `instr_valid` is set in the run state, `exc_flags[i]` raises an exception with cause code i. The codes are 0 fetch misaligned, 1 fetch access, 2 illegal, 3 breakpoint, 4 load misaligned, 5 load access, 6 store misaligned and 7 store access. `op_ecall` raises code 11. The lowest code wins. `trap_taken` is 1 and `trap_target` is the vector in the same cycle, and the return address takes `pc` at the next edge.
- R6: The trap value becomes `addr_val` for codes 0, 4, 5, 6 and 7, becomes `pc` for codes 1 and 3, and becomes 0 for code 2, for code 11 and for every interrupt.
- R7: On trap entry the saved-enable bit takes the global enable and the global enable clears. A CSR write in the same cycle as a trap is dropped.
- R8: An interrupt is taken only when the global enable and its own enable bit are both set. Priority is external, then software, then timer, and any interrupt beats any exception. The cause has bit 31 set with code 11, 3 or 7.
- R9: A valid `op_mret` with no trap sets `trap_taken`, drives `trap_target` to the return address and copies the saved-enable bit into the global enable. The saved-enable bit is unchanged.
- R10: A valid `op_wfi` with no trap drops `advance` in that cycle, stores `next_pc` as the return address and parks the block. While parked, `advance` stays 0 until some line is pending with its enable bit set. At that point `advance` is 1, and a trap is taken (return address kept) only if the global enable is set.
- R11: Addresses 0x7C0 to 0x7FF go to the coprocessor. `cop_addr` is `csr_addr[5:0]`, `cop_wdata` is `csr_wdata`, and `cop_we` pulses for an accepted write. Reads return `cop_rdata`.
- R12: With `instr_valid` low, or while parked, faults, system ops and CSR writes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Current instruction is live (not flushed) |
| exc_flags | input | 8 | Synchronous fault flags, bit i = cause code i |
| op_ecall | input | 1 | Environment call decoded |
| op_mret | input | 1 | Return from trap decoded |
| op_wfi | input | 1 | Wait for interrupt decoded |
| pc | input | 32 | Address of current instruction |
| next_pc | input | 32 | Address after current instruction |
| addr_val | input | 32 | Computed address for misaligned/access faults |
| irq_ext | input | 1 | External interrupt level |
| irq_sw | input | 1 | Software interrupt level |
| irq_tmr | input | 1 | Timer interrupt level |
| csr_we | input | 1 | CSR write request |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data |
| cnt_cycle | input | 64 | Cycle counter value |
| cnt_time | input | 64 | Time counter value |
| cnt_instret | input | 64 | Retired-instruction counter value |
| cop_rdata | input | 32 | Coprocessor read data |
| cop_addr | output | 6 | Coprocessor register offset |
| cop_wdata | output | 32 | Coprocessor write data |
| cop_we | output | 1 | Coprocessor write strobe |
| trap_taken | output | 1 | Redirect this cycle (trap or return) |
| trap_target | output | 32 | Redirect address |
| advance | output | 1 | Pipeline may advance |

## Verification
The bench drives several faults at once to check that the lowest code wins. A design that scanned the flags in the wrong direction would report a load access fault where an illegal instruction is due. It checks that an interrupt beats a simultaneous exception and that the three interrupt sources are ordered. A wrong order shows up as the wrong cause, with bit 31 missing or the wrong code. It parks a wait instruction, offers faults while parked, then wakes it once with interrupts globally disabled and once enabled. A design that overwrote the return address with the current PC on the wake-up trap would return into the wait instead of past it. It also places a CSR write in the same cycle as a trap and under a low `instr_valid`, where a design that let the write through would leave a modified scratch register.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_WAIT = 1'b1
    } mt_state_e;

    localparam logic [11:0] A_STATUS  = 12'h300;
    localparam logic [11:0] A_ISA     = 12'h301;
    localparam logic [11:0] A_IEN     = 12'h304;
    localparam logic [11:0] A_VEC     = 12'h305;
    localparam logic [11:0] A_SCRATCH = 12'h340;
    localparam logic [11:0] A_EPC     = 12'h341;
    localparam logic [11:0] A_CAUSE   = 12'h342;
    localparam logic [11:0] A_TVAL    = 12'h343;
    localparam logic [11:0] A_IPEND   = 12'h344;
    localparam logic [11:0] A_CYC_LO  = 12'hC00;
    localparam logic [11:0] A_TIM_LO  = 12'hC01;
    localparam logic [11:0] A_RET_LO  = 12'hC02;
    localparam logic [11:0] A_CYC_HI  = 12'hC80;
    localparam logic [11:0] A_TIM_HI  = 12'hC81;
    localparam logic [11:0] A_RET_HI  = 12'hC82;

    localparam logic [5:0]  COP_WIN_TAG = 6'h1F;

    localparam int GIE_BIT  = 3;
    localparam int SGIE_BIT = 7;
    localparam int SW_BIT   = 3;
    localparam int TM_BIT   = 7;
    localparam int EX_BIT   = 11;

    localparam logic [4:0] CODE_ECALL  = 5'd11;
    localparam logic [4:0] CODE_IRQ_EX = 5'd11;
    localparam logic [4:0] CODE_IRQ_SW = 5'd3;
    localparam logic [4:0] CODE_IRQ_TM = 5'd7;

    localparam logic [31:0] ISA_WORD = 32'h4000_0100;

    function automatic logic in_cop_window(input logic [11:0] a);
        return a[11:6] == COP_WIN_TAG;
    endfunction

endpackage

// File: rtl/mtrap_cause.sv
module mtrap_cause #(
    parameter int XLEN    = 32,
    parameter int NUM_EXC = 8
) (
    input  logic                valid,
    input  logic [NUM_EXC-1:0]  exc_flags,
    input  logic                ecall,
    input  logic [2:0]          irq_live,
    input  logic [XLEN-1:0]     pc,
    input  logic [XLEN-1:0]     addr_val,
    output logic                take_irq,
    output logic                take_exc,
    output logic [XLEN-1:0]     cause,
    output logic [XLEN-1:0]     tval
);
    import mtrap_pkg::*;

    localparam int CODE_W = 5;

    logic [CODE_W-1:0] code;

    // irq_live: [2] external, [1] software, [0] timer
    always_comb begin
        take_irq = |irq_live;
        take_exc = valid && ((|exc_flags) || ecall);
        code     = '0;
        cause    = '0;
        tval     = '0;
        if (take_irq) begin
            if (irq_live[2])      code = CODE_IRQ_EX;
            else if (irq_live[1]) code = CODE_IRQ_SW;
            else                  code = CODE_IRQ_TM;
            cause = {1'b1, {(XLEN-1-CODE_W){1'b0}}, code};
        end else if (take_exc) begin
            if (ecall) code = CODE_ECALL;
            for (int i = NUM_EXC - 1; i >= 0; i--) begin
                if (exc_flags[i]) code = CODE_W'(i);
            end
            cause = {{(XLEN-CODE_W){1'b0}}, code};
            case (code)
                5'd0, 5'd4, 5'd5, 5'd6, 5'd7: tval = addr_val;
                5'd1, 5'd3:                   tval = pc;
                default:                      tval = '0;
            endcase
        end
    end

endmodule

// File: rtl/mtrap_csr_file.sv
module mtrap_csr_file #(
    parameter int XLEN  = 32,
    parameter int CNT_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_en,
    input  logic              keep_epc,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_cause,
    input  logic [XLEN-1:0]   trap_tval,
    input  logic              mret_en,
    input  logic              wfi_en,
    input  logic [XLEN-1:0]   wfi_next_pc,
    input  logic              wr_en,
    input  logic [11:0]       addr,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [2:0]        irq_pend,
    input  logic [CNT_W-1:0]  cnt_cycle,
    input  logic [CNT_W-1:0]  cnt_time,
    input  logic [CNT_W-1:0]  cnt_instret,
    input  logic [XLEN-1:0]   cop_rdata,
    output logic [XLEN-1:0]   rd_data,
    output logic              gie,
    output logic              sgie,
    output logic [2:0]        ien,
    output logic [XLEN-1:0]   vec,
    output logic [XLEN-1:0]   epc
);
    import mtrap_pkg::*;

    localparam int HALF = CNT_W / 2;

    logic [XLEN-1:0] scratch_q, cause_q, tval_q;
    logic [XLEN-1:0] ipend_word, ien_word, status_word;

    // ien / irq_pend: [2] external, [1] software, [0] timer
    always_ff @(posedge clk) begin
        if (rst) begin
            gie       <= 1'b0;
            sgie      <= 1'b0;
            ien       <= '0;
            vec       <= '0;
            epc       <= '0;
            scratch_q <= '0;
            cause_q   <= '0;
            tval_q    <= '0;
        end else if (trap_en) begin
            sgie    <= gie;
            gie     <= 1'b0;
            cause_q <= trap_cause;
            tval_q  <= trap_tval;
            if (!keep_epc) epc <= trap_pc;
        end else if (mret_en) begin
            gie <= sgie;
        end else begin
            if (wfi_en) epc <= wfi_next_pc;
            if (wr_en) begin
                case (addr)
                    A_STATUS: begin
                        gie  <= wr_data[GIE_BIT];
                        sgie <= wr_data[SGIE_BIT];
                    end
                    A_IEN:     ien <= {wr_data[EX_BIT], wr_data[SW_BIT], wr_data[TM_BIT]};
                    A_VEC:     vec <= {wr_data[XLEN-1:2], 2'b00};
                    A_SCRATCH: scratch_q <= wr_data;
                    A_EPC:     epc <= wr_data;
                    A_CAUSE:   cause_q <= wr_data;
                    A_TVAL:    tval_q <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        ipend_word = '0;
        ipend_word[EX_BIT] = irq_pend[2];
        ipend_word[SW_BIT] = irq_pend[1];
        ipend_word[TM_BIT] = irq_pend[0];
        ien_word = '0;
        ien_word[EX_BIT] = ien[2];
        ien_word[SW_BIT] = ien[1];
        ien_word[TM_BIT] = ien[0];
        status_word = '0;
        status_word[GIE_BIT]  = gie;
        status_word[SGIE_BIT] = sgie;
    end

    always_comb begin
        if (in_cop_window(addr)) begin
            rd_data = cop_rdata;
        end else begin
            case (addr)
                A_STATUS:  rd_data = status_word;
                A_ISA:     rd_data = ISA_WORD;
                A_IEN:     rd_data = ien_word;
                A_VEC:     rd_data = vec;
                A_SCRATCH: rd_data = scratch_q;
                A_EPC:     rd_data = epc;
                A_CAUSE:   rd_data = cause_q;
                A_TVAL:    rd_data = tval_q;
                A_IPEND:   rd_data = ipend_word;
                A_CYC_LO:  rd_data = cnt_cycle[HALF-1:0];
                A_TIM_LO:  rd_data = cnt_time[HALF-1:0];
                A_RET_LO:  rd_data = cnt_instret[HALF-1:0];
                A_CYC_HI:  rd_data = cnt_cycle[CNT_W-1:HALF];
                A_TIM_HI:  rd_data = cnt_time[CNT_W-1:HALF];
                A_RET_HI:  rd_data = cnt_instret[CNT_W-1:HALF];
                default:   rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl #(
    parameter int XLEN    = 32,
    parameter int NUM_EXC = 8,
    parameter int CNT_W   = 64,
    parameter int COP_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [NUM_EXC-1:0] exc_flags,
    input  logic               op_ecall,
    input  logic               op_mret,
    input  logic               op_wfi,
    input  logic [XLEN-1:0]    pc,
    input  logic [XLEN-1:0]    next_pc,
    input  logic [XLEN-1:0]    addr_val,
    input  logic               irq_ext,
    input  logic               irq_sw,
    input  logic               irq_tmr,
    input  logic               csr_we,
    input  logic [11:0]        csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    input  logic [CNT_W-1:0]   cnt_cycle,
    input  logic [CNT_W-1:0]   cnt_time,
    input  logic [CNT_W-1:0]   cnt_instret,
    input  logic [XLEN-1:0]    cop_rdata,
    output logic [COP_W-1:0]   cop_addr,
    output logic [XLEN-1:0]    cop_wdata,
    output logic               cop_we,
    output logic               trap_taken,
    output logic [XLEN-1:0]    trap_target,
    output logic               advance
);
    import mtrap_pkg::*;

    mt_state_e state_q, state_d;

    logic            live_v, st_wait, wake;
    logic            trap_fire, mret_fire, wfi_fire, wr_fire;
    logic            take_irq, take_exc;
    logic            gie, sgie;
    logic [2:0]      ien, pend, irq_live;
    logic [XLEN-1:0] vec, epc, t_cause, t_tval;

    assign pend     = {irq_ext, irq_sw, irq_tmr};
    assign st_wait  = (state_q == ST_WAIT);
    assign live_v   = instr_valid && !st_wait;
    assign wake     = |(pend & ien);
    assign irq_live = gie ? (pend & ien) : 3'b000;

    mtrap_cause #(.XLEN(XLEN), .NUM_EXC(NUM_EXC)) u_cause (
        .valid     (live_v),
        .exc_flags (exc_flags),
        .ecall     (op_ecall),
        .irq_live  (irq_live),
        .pc        (pc),
        .addr_val  (addr_val),
        .take_irq  (take_irq),
        .take_exc  (take_exc),
        .cause     (t_cause),
        .tval      (t_tval)
    );

    assign trap_fire = take_irq || take_exc;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        mret_fire = 1'b0;
        wfi_fire  = 1'b0;
        advance   = 1'b1;
        unique case (state_q)
            ST_RUN: begin
                mret_fire = live_v && op_mret && !trap_fire;
                wfi_fire  = live_v && op_wfi && !trap_fire;
                advance   = !wfi_fire;
                if (wfi_fire) state_d = ST_WAIT;   // RUN_TO_WAIT
            end
            ST_WAIT: begin
                advance = wake;
                if (wake) state_d = ST_RUN;        // WAIT_TO_RUN
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign wr_fire     = live_v && csr_we && !trap_fire;
    assign trap_taken  = trap_fire || mret_fire;
    assign trap_target = mret_fire ? epc : vec;
    assign cop_addr    = csr_addr[COP_W-1:0];
    assign cop_wdata   = csr_wdata;
    assign cop_we      = wr_fire && in_cop_window(csr_addr);

    mtrap_csr_file #(.XLEN(XLEN), .CNT_W(CNT_W)) u_csr (
        .clk         (clk),
        .rst         (rst),
        .trap_en     (trap_fire),
        .keep_epc    (st_wait),
        .trap_pc     (pc),
        .trap_cause  (t_cause),
        .trap_tval   (t_tval),
        .mret_en     (mret_fire),
        .wfi_en      (wfi_fire),
        .wfi_next_pc (next_pc),
        .wr_en       (wr_fire),
        .addr        (csr_addr),
        .wr_data     (csr_wdata),
        .irq_pend    (pend),
        .cnt_cycle   (cnt_cycle),
        .cnt_time    (cnt_time),
        .cnt_instret (cnt_instret),
        .cop_rdata   (cop_rdata),
        .rd_data     (csr_rdata),
        .gie         (gie),
        .sgie        (sgie),
        .ien         (ien),
        .vec         (vec),
        .epc         (epc)
    );

endmodule

// File: rtl/mtrap_ctrl_chk.sv
module mtrap_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        instr_valid,
    input logic        trap_fire,
    input logic        mret_fire,
    input logic        st_wait,
    input logic        wake,
    input logic        gie,
    input logic        sgie,
    input logic        advance,
    input logic        trap_taken,
    input logic [31:0] trap_target,
    input logic        cop_we,
    input logic [11:0] csr_addr
);
    // R7: entry saves and clears the global enable
    a_r7_entry_saves_enable: assert property (@(posedge clk) disable iff (rst)
        trap_fire |=> (!gie && sgie == $past(gie)));

    // R9: return restores the global enable from the saved bit
    a_r9_return_restores: assert property (@(posedge clk) disable iff (rst)
        mret_fire |=> (gie == $past(sgie)));

    // R9: a return is reported as a redirect
    a_r9_return_redirects: assert property (@(posedge clk) disable iff (rst)
        mret_fire |-> trap_taken);

    // R10: parked with nothing enabled pending keeps the pipeline held
    a_r10_park_holds: assert property (@(posedge clk) disable iff (rst)
        (st_wait && !wake) |-> !advance);

    // R8: an interrupt-only trap needs the global enable
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (trap_fire && !instr_valid) |-> gie);

    // R11: the coprocessor strobe stays inside its window
    a_r11_cop_in_window: assert property (@(posedge clk) disable iff (rst)
        cop_we |-> (csr_addr[11:6] == 6'h1F));

    // R2: trap vector is word aligned
    a_r2_vector_aligned: assert property (@(posedge clk) disable iff (rst)
        trap_fire |-> (trap_target[1:0] == 2'b00));
endmodule

bind mtrap_ctrl mtrap_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .trap_fire   (trap_fire),
    .mret_fire   (mret_fire),
    .st_wait     (st_wait),
    .wake        (wake),
    .gie         (gie),
    .sgie        (sgie),
    .advance     (advance),
    .trap_taken  (trap_taken),
    .trap_target (trap_target),
    .cop_we      (cop_we),
    .csr_addr    (csr_addr)
);

// File: tb/mtrap_ctrl_tb.sv
module mtrap_ctrl_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid, op_ecall, op_mret, op_wfi;
    logic [7:0]  exc_flags;
    logic [31:0] pc, next_pc, addr_val;
    logic        irq_ext, irq_sw, irq_tmr, csr_we;
    logic [11:0] csr_addr;
    logic [31:0] csr_wdata, csr_rdata, cop_rdata, cop_wdata, trap_target;
    logic [63:0] cnt_cycle, cnt_time, cnt_instret;
    logic [5:0]  cop_addr;
    logic        cop_we, trap_taken, advance;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_P/2) clk = ~clk;

    mtrap_ctrl u_dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .exc_flags(exc_flags),
        .op_ecall(op_ecall), .op_mret(op_mret), .op_wfi(op_wfi),
        .pc(pc), .next_pc(next_pc), .addr_val(addr_val),
        .irq_ext(irq_ext), .irq_sw(irq_sw), .irq_tmr(irq_tmr),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .cnt_cycle(cnt_cycle), .cnt_time(cnt_time), .cnt_instret(cnt_instret),
        .cop_rdata(cop_rdata), .cop_addr(cop_addr), .cop_wdata(cop_wdata), .cop_we(cop_we),
        .trap_taken(trap_taken), .trap_target(trap_target), .advance(advance)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic idle();
        instr_valid = 0; exc_flags = 0; op_ecall = 0; op_mret = 0; op_wfi = 0;
        csr_we = 0; csr_wdata = 0;
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
        idle();
        instr_valid = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
        tick();
        idle();
    endtask

    task automatic csr_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        idle();
        csr_addr = a;
        #1;
        check(csr_rdata, exp, tag);
    endtask

    task automatic t_reset();
        csr_chk(12'h300, 0, "R1 status");
        csr_chk(12'h304, 0, "R1 enables");
        csr_chk(12'h305, 0, "R1 vector");
        csr_chk(12'h341, 0, "R1 epc");
        csr_chk(12'h342, 0, "R1 cause");
        csr_chk(12'h340, 0, "R1 scratch");
        check(advance, 1, "R1 advance");
        check(trap_taken, 0, "R1 trap_taken");
    endtask

    task automatic t_csr_rw();
        csr_wr(12'h305, 32'h1000_0103);
        csr_chk(12'h305, 32'h1000_0100, "R2 vector low bits");
        csr_wr(12'h340, 32'hDEAD_BEEF);
        csr_chk(12'h340, 32'hDEAD_BEEF, "R2 scratch");
        csr_wr(12'h304, 32'hFFFF_FFFF);
        csr_chk(12'h304, 32'h0000_0888, "R2 enables mask");
        csr_wr(12'h300, 32'hFFFF_FFFF);
        csr_chk(12'h300, 32'h0000_0088, "R2 status mask");
        csr_wr(12'h300, 0);
        csr_wr(12'h304, 0);
        csr_chk(12'h345, 0, "R2 unimplemented");
        csr_wr(12'h301, 0);
        csr_chk(12'h301, 32'h4000_0100, "R3 isa word");
        irq_sw = 1; irq_ext = 1;
        csr_chk(12'h344, 32'h0000_0808, "R3 pending view");
        irq_sw = 0; irq_ext = 0; irq_tmr = 1;
        csr_chk(12'h344, 32'h0000_0080, "R3 pending timer");
        irq_tmr = 0;
    endtask

    task automatic t_counters();
        csr_chk(12'hC00, 32'h3333_4444, "R4 cycle lo");
        csr_chk(12'hC80, 32'h1111_2222, "R4 cycle hi");
        csr_chk(12'hC01, 32'h7777_8888, "R4 time lo");
        csr_chk(12'hC81, 32'h5555_6666, "R4 time hi");
        csr_chk(12'hC02, 32'hCCCC_DDDD, "R4 instret lo");
        csr_chk(12'hC82, 32'hAAAA_BBBB, "R4 instret hi");
    endtask

    task automatic fault(input logic [7:0] f, input logic ec, input logic [31:0] e_cause,
                         input logic [31:0] e_tval, input string tag);
        idle();
        instr_valid = 1; exc_flags = f; op_ecall = ec;
        #1;
        check(trap_taken, 1, {tag, " taken"});
        check(trap_target, 32'h100, {tag, " target"});
        tick();
        idle();
        csr_chk(12'h342, e_cause, {tag, " cause"});
        csr_chk(12'h343, e_tval, {tag, " tval"});
        csr_chk(12'h341, pc, {tag, " epc"});
    endtask

    task automatic t_exceptions();
        csr_wr(12'h305, 32'h100);
        pc = 32'h200; next_pc = 32'h204; addr_val = 32'h3001;
        fault(8'h24, 0, 2, 0, "R5 lowest code illegal");
        fault(8'h20, 0, 5, 32'h3001, "R6 load access tval");
        fault(8'h0A, 0, 1, 32'h200, "R6 fetch access tval pc");
        fault(8'h08, 0, 3, 32'h200, "R6 breakpoint tval pc");
        fault(8'h00, 1, 11, 0, "R5 ecall");
        fault(8'h41, 1, 0, 32'h3001, "R5 misaligned fetch beats ecall");
    endtask

    task automatic t_entry_mret();
        csr_wr(12'h340, 32'h11);
        csr_wr(12'h300, 32'h8);
        idle();
        instr_valid = 1; op_ecall = 1; csr_we = 1; csr_addr = 12'h340; csr_wdata = 32'h55;
        tick();
        idle();
        csr_chk(12'h300, 32'h80, "R7 enable saved and cleared");
        csr_chk(12'h340, 32'h11, "R7 write dropped on trap");
        csr_wr(12'h341, 32'h400);
        idle();
        instr_valid = 1; op_mret = 1;
        #1;
        check(trap_taken, 1, "R9 mret taken");
        check(trap_target, 32'h400, "R9 mret target");
        tick();
        idle();
        csr_chk(12'h300, 32'h88, "R9 enable restored");
    endtask

    task automatic t_irqs();
        csr_wr(12'h304, 32'h888);
        idle();
        instr_valid = 1; exc_flags = 8'h04; irq_tmr = 1; irq_sw = 1;
        #1;
        check(trap_taken, 1, "R8 irq taken");
        tick();
        idle();
        csr_chk(12'h342, 32'h8000_0003, "R8 software beats timer and exception");
        csr_chk(12'h343, 0, "R6 irq tval zero");
        #1;
        check(trap_taken, 0, "R8 no irq with enable cleared");
        irq_tmr = 0; irq_sw = 0;
        csr_wr(12'h304, 32'h080);
        csr_wr(12'h300, 32'h8);
        irq_ext = 1;
        #1;
        check(trap_taken, 0, "R8 disabled source ignored");
        irq_tmr = 1;
        #1;
        check(trap_taken, 1, "R8 timer taken");
        tick();
        csr_chk(12'h342, 32'h8000_0007, "R8 timer cause");
        irq_tmr = 0; irq_ext = 0;
        csr_wr(12'h304, 32'h888);
        csr_wr(12'h300, 32'h8);
        irq_ext = 1; irq_sw = 1; irq_tmr = 1;
        tick();
        csr_chk(12'h342, 32'h8000_000B, "R8 external first");
        irq_ext = 0; irq_sw = 0; irq_tmr = 0;
    endtask

    task automatic t_wfi();
        csr_wr(12'h300, 0);
        csr_wr(12'h304, 32'h800);
        idle();
        pc = 32'h500; next_pc = 32'h504;
        instr_valid = 1; op_wfi = 1;
        #1;
        check(advance, 0, "R10 wfi cycle holds");
        check(trap_taken, 0, "R10 wfi no trap");
        tick();
        #1;
        check(advance, 0, "R10 parked holds");
        tick();
        check(advance, 0, "R10 parked holds 2");
        irq_ext = 1;
        #1;
        check(advance, 1, "R10 wake resumes");
        check(trap_taken, 0, "R10 wake without trap");
        tick();
        irq_ext = 0;
        idle();
        #1;
        check(advance, 1, "R10 back in run");
        csr_chk(12'h341, 32'h504, "R10 epc next pc");
        csr_wr(12'h300, 32'h8);
        idle();
        pc = 32'h600; next_pc = 32'h604;
        instr_valid = 1; op_wfi = 1;
        tick();
        exc_flags = 8'h04; csr_we = 1; csr_addr = 12'h340; csr_wdata = 32'h99;
        #1;
        check(trap_taken, 0, "R12 fault ignored while parked");
        check(advance, 0, "R12 parked ignores instruction");
        tick();
        idle();
        csr_chk(12'h340, 32'h11, "R12 write ignored while parked");
        irq_ext = 1;
        #1;
        check(trap_taken, 1, "R10 wake trap");
        check(advance, 1, "R10 wake trap advance");
        check(trap_target, 32'h100, "R10 wake trap target");
        tick();
        irq_ext = 0;
        csr_chk(12'h341, 32'h604, "R10 epc kept on wake trap");
        csr_chk(12'h342, 32'h8000_000B, "R10 wake cause");
    endtask

    task automatic t_cop();
        idle();
        instr_valid = 1; csr_we = 1; csr_addr = 12'h7C5; csr_wdata = 32'hABCD;
        #1;
        check(cop_we, 1, "R11 strobe in window");
        check(cop_addr, 6'h05, "R11 offset");
        check(cop_wdata, 32'hABCD, "R11 data");
        csr_addr = 12'h7BF;
        #1;
        check(cop_we, 0, "R11 below window");
        tick();
        idle();
        cop_rdata = 32'h1234;
        csr_chk(12'h7FF, 32'h1234, "R11 read return");
        check(cop_addr, 6'h3F, "R11 top offset");
        csr_chk(12'h800, 0, "R2 above window reads zero");
    endtask

    task automatic t_invalid();
        idle();
        exc_flags = 8'hFF; op_ecall = 1; op_mret = 1; csr_we = 1; csr_addr = 12'h340;
        csr_wdata = 32'h77;
        #1;
        check(trap_taken, 0, "R12 invalid no trap");
        check(cop_we, 0, "R12 invalid no strobe");
        tick();
        idle();
        csr_chk(12'h340, 32'h11, "R12 invalid write ignored");
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1;
        idle();
        pc = 0; next_pc = 0; addr_val = 0; csr_addr = 0;
        irq_ext = 0; irq_sw = 0; irq_tmr = 0; cop_rdata = 0;
        cnt_cycle = 64'h1111_2222_3333_4444;
        cnt_time = 64'h5555_6666_7777_8888;
        cnt_instret = 64'hAAAA_BBBB_CCCC_DDDD;
        repeat (3) tick();
        rst = 0;
        tick();
        t_reset();
        t_csr_rw();
        t_counters();
        t_exceptions();
        t_entry_mret();
        t_irqs();
        t_wfi();
        t_cop();
        t_invalid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule